// File: doc/BRIEF.md
# SCSI Initiator Selection and Command Sequencer

This block carries out, on its own, the opening part of a SCSI initiator transaction. Software first loads a byte count and fills a FIFO with command bytes. It then strobes in the select command, code 0x0B. From that point the sequencer needs no further help. It watches the bus until the bus is free and arbitrates with its own ID. If it wins, it selects the chosen target without raising ATN. It then sends the command bytes from the FIFO, one byte for each REQ/ACK handshake, while the target holds the bus in the command phase.

The result is reported in four sticky flags and an interrupt line:
- successful completion, which also sets an initiator-mode indication;
- selection timeout;
- phase mismatch;
- a command strobe that arrived while a sequence was already running.

Losing arbitration is not an error. The sequencer lets go of the bus and waits for the next bus-free window. Phases after the command phase are handled elsewhere, and so is parity.

Top module: `scsi_sel_cmd_seq`

## Requirements
- R1: After reset, BSY, SEL, ATN, ACK and the data-bus enable are negated. All four flags, `irq` and `init_mode` are 0.
- R2: While the block is idle, a strobe with code 0x0B starts a sequence even when `init_mode` is 1. Starting clears `init_mode` and all four flags. While idle, a strobe with any other code has no effect.
- R3: Any strobe that arrives while a sequence is running sets `int_cmd_err`. The running sequence still completes with the same bytes and result.
- R4: BSY and the own-ID bit are driven only after both BSY and SEL have been seen negated for FREE_CYC consecutive cycles. Any busy cycle restarts the count.
- R5: After ARB_CYC cycles of arbitration, the block wins if no data-bus bit above its own ID is set. On a loss it releases the bus and waits again for FREE_CYC free cycles.
- R6: On a win, SEL is asserted while BSY is held for SEL_CYC cycles. BSY is then released and SEL kept. The data bus carries the own-ID bit OR the target-ID bit during selection. ATN is never asserted.
- R7: The block releases SEL and the data bus once the target drives BSY. If BSY does not arrive within SEL_TMO cycles, it sets `int_sel_tmo` and releases the bus.
- R8: The command phase is C/D=1, I/O=0, MSG=0. On REQ in that phase, the block drives the FIFO head byte, pops the FIFO and asserts ACK until REQ is negated. Exactly `xfer_len` bytes are sent, in FIFO order.
- R9: If REQ arrives in any other phase, the block stops without asserting ACK or popping the FIFO, and sets `int_phase`.
- R10: After the last byte (or right after selection when `xfer_len` is 0), the block sets `int_good` and `init_mode`.
- R11: `irq` is high whenever any of the four flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| own_id | input | 3 | Own SCSI ID |
| tgt_id | input | 3 | Target SCSI ID |
| xfer_len | input | 8 | Number of command bytes |
| fifo_rdata | input | 8 | FIFO head byte |
| fifo_rd | output | 1 | FIFO pop strobe |
| bsy_in | input | 1 | BSY as seen on the bus |
| sel_in | input | 1 | SEL as seen on the bus |
| req_in | input | 1 | REQ from the target |
| cd_in | input | 1 | C/D phase line |
| io_in | input | 1 | I/O phase line |
| msg_in | input | 1 | MSG phase line |
| db_in | input | 8 | Data bus as seen |
| bsy_out | output | 1 | BSY drive |
| sel_out | output | 1 | SEL drive |
| atn_out | output | 1 | ATN drive |
| ack_out | output | 1 | ACK drive |
| db_out | output | 8 | Data bus value |
| db_oe | output | 1 | Data bus enable |
| int_good | output | 1 | Sequence completed |
| int_sel_tmo | output | 1 | Selection timeout |
| int_phase | output | 1 | Phase mismatch on REQ |
| int_cmd_err | output | 1 | Command strobed while running |
| irq | output | 1 | Interrupt |
| init_mode | output | 1 | Initiator mode reached |

## Verification
A new command strobe can land in the same cycle as the completion of the final byte. The target negates REQ for the last byte and, at that same negative clock edge, the bench raises `cmd_valid` with code 0x0B. The sequence is still running at the following edge, so the check expects both `int_good` and `int_cmd_err` to be set. It also expects every byte to have been transferred and `init_mode` to be 1. A second case pulses the strobe in the middle of the transfer and judges the outcome the same way.

// File: rtl/scsi_sel_cmd_seq.sv
module scsi_sel_cmd_seq #(
  parameter int ID_W     = 3,
  parameter int CNT_W    = 8,
  parameter int FREE_CYC = 8,
  parameter int ARB_CYC  = 4,
  parameter int SEL_CYC  = 2,
  parameter int SEL_TMO  = 64,
  parameter logic [7:0] OP_SEL = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ID_W-1:0]   own_id,
  input  logic [ID_W-1:0]   tgt_id,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic [(1<<ID_W)-1:0] fifo_rdata,
  output logic              fifo_rd,
  input  logic              bsy_in,
  input  logic              sel_in,
  input  logic              req_in,
  input  logic              cd_in,
  input  logic              io_in,
  input  logic              msg_in,
  input  logic [(1<<ID_W)-1:0] db_in,
  output logic              bsy_out,
  output logic              sel_out,
  output logic              atn_out,
  output logic              ack_out,
  output logic [(1<<ID_W)-1:0] db_out,
  output logic              db_oe,
  output logic              int_good,
  output logic              int_sel_tmo,
  output logic              int_phase,
  output logic              int_cmd_err,
  output logic              irq,
  output logic              init_mode
);
  localparam int NID = 1 << ID_W;
  localparam int TW  = $clog2(FREE_CYC + ARB_CYC + SEL_CYC + SEL_TMO + 1);

  typedef enum logic [2:0] {S_IDLE, S_FREE, S_ARB, S_SEL, S_SELW, S_CMD, S_ACK} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [CNT_W-1:0] cnt;
  logic [NID-1:0] dreg;

  wire            bus_free = !bsy_in && !sel_in;
  wire            cmd_ph   = cd_in && !io_in && !msg_in;
  wire [NID-1:0]  own_bit  = NID'(1) << own_id;
  wire [NID-1:0]  tgt_bit  = NID'(1) << tgt_id;
  wire [NID-1:0]  own_up   = own_bit << 1;
  wire [NID-1:0]  hi_mask  = ~(own_up - NID'(1));

  assign bsy_out = (st == S_ARB) || (st == S_SEL);
  assign sel_out = (st == S_SEL) || (st == S_SELW);
  assign atn_out = 1'b0;
  assign ack_out = (st == S_ACK);
  assign db_oe   = bsy_out || sel_out || ack_out;
  assign db_out  = ack_out ? dreg : (sel_out ? (own_bit | tgt_bit) : own_bit);
  assign fifo_rd = (st == S_CMD) && req_in && cmd_ph;
  assign irq     = int_good | int_sel_tmo | int_phase | int_cmd_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; cnt <= '0; dreg <= '0;
      int_good <= 1'b0; int_sel_tmo <= 1'b0; int_phase <= 1'b0;
      int_cmd_err <= 1'b0; init_mode <= 1'b0;
    end else begin
      if (cmd_valid && st != S_IDLE) int_cmd_err <= 1'b1;
      case (st)
        S_IDLE: if (cmd_valid && cmd_code == OP_SEL) begin
          st <= S_FREE; tmr <= '0; cnt <= xfer_len;
          int_good <= 1'b0; int_sel_tmo <= 1'b0; int_phase <= 1'b0;
          int_cmd_err <= 1'b0; init_mode <= 1'b0;
        end
        S_FREE: if (!bus_free) tmr <= '0;
          else if (tmr == TW'(FREE_CYC - 1)) begin st <= S_ARB; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_ARB: if (tmr == TW'(ARB_CYC - 1)) begin
            tmr <= '0;
            st  <= ((db_in & hi_mask) == '0) ? S_SEL : S_FREE;
          end else tmr <= tmr + 1'b1;
        S_SEL: if (tmr == TW'(SEL_CYC - 1)) begin st <= S_SELW; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_SELW: if (bsy_in) begin
            if (cnt == '0) begin st <= S_IDLE; int_good <= 1'b1; init_mode <= 1'b1; end
            else st <= S_CMD;
          end else if (tmr == TW'(SEL_TMO - 1)) begin
            st <= S_IDLE; int_sel_tmo <= 1'b1;
          end else tmr <= tmr + 1'b1;
        S_CMD: if (req_in) begin
            if (cmd_ph) begin dreg <= fifo_rdata; st <= S_ACK; end
            else begin int_phase <= 1'b1; st <= S_IDLE; end
          end
        S_ACK: if (!req_in) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin st <= S_IDLE; int_good <= 1'b1; init_mode <= 1'b1; end
            else st <= S_CMD;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ARB_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(!bsy_in && !sel_in)); // R4
  AST_SEL_WITH_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_out) |-> bsy_out); // R6
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_sel_tmo) |-> !sel_out && !bsy_out && !db_oe); // R7
  AST_ACK_ON_CMD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(req_in && cd_in && !io_in && !msg_in)); // R8
  AST_PHASE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_phase) |-> !ack_out && !fifo_rd); // R9
  AST_GOOD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_good) |-> init_mode && !sel_out && !ack_out); // R10
endmodule

// File: tb/scsi_sel_cmd_seq_tb.sv
module scsi_sel_cmd_seq_tb_top;
  localparam int FREE = 4, ARB = 3, SELC = 2, TMO = 20;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic       cmd_valid = 0;
  logic [7:0] cmd_code = 0;
  logic [2:0] own_id = 0, tgt_id = 0;
  logic [7:0] xfer_len = 0;
  logic tgt_bsy = 0, oth_bsy = 0, req = 0, cd = 0, io = 0, msg = 0;
  logic [7:0] oth_db = 0;
  logic fifo_rd, bsy_out, sel_out, atn_out, ack_out, db_oe;
  logic [7:0] db_out;
  logic int_good, int_sel_tmo, int_phase, int_cmd_err, irq, init_mode;
  int   pops = 0, arbs = 0, atn_seen = 0;
  logic bsy_q = 0;

  wire [7:0] fifo_rdata = 8'(pops * 37 + 11);
  wire       bsy_in = bsy_out | tgt_bsy | oth_bsy;
  wire [7:0] db_in  = (db_oe ? db_out : 8'h00) | oth_db;

  scsi_sel_cmd_seq #(.FREE_CYC(FREE), .ARB_CYC(ARB), .SEL_CYC(SELC), .SEL_TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .own_id(own_id), .tgt_id(tgt_id), .xfer_len(xfer_len), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .bsy_in(bsy_in), .sel_in(sel_out), .req_in(req), .cd_in(cd),
    .io_in(io), .msg_in(msg), .db_in(db_in), .bsy_out(bsy_out), .sel_out(sel_out),
    .atn_out(atn_out), .ack_out(ack_out), .db_out(db_out), .db_oe(db_oe),
    .int_good(int_good), .int_sel_tmo(int_sel_tmo), .int_phase(int_phase),
    .int_cmd_err(int_cmd_err), .irq(irq), .init_mode(init_mode));

  always @(posedge clk) begin
    bsy_q <= bsy_out;
    if (bsy_out && !bsy_q) arbs <= arbs + 1;
    if (fifo_rd) pops <= pops + 1;
    if (atn_out) atn_seen <= atn_seen + 1;
  end

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // outcome codes: 0 good, 1 selection timeout, 2 phase mismatch
  localparam int NV = 6;
  localparam int V_OWN [NV] = '{7, 3, 5, 2, 6, 4};
  localparam int V_TGT [NV] = '{0, 5, 1, 4, 3, 0};
  localparam int V_LEN [NV] = '{6, 3, 2, 4, 5, 1};
  localparam int V_CID [NV] = '{-1, 6, 2, -1, -1, -1};
  localparam int V_RSP [NV] = '{1, 1, 1, 0, 1, 1};
  localparam int V_BAD [NV] = '{-1, -1, -1, -1, 2, -1};
  localparam int V_OUT [NV] = '{0, 0, 0, 1, 2, 0};
  localparam int V_ARB [NV] = '{1, 2, 1, 1, 1, 1};

  int nbytes, bad_bytes, arb_base, pstart, seldb;

  task automatic run_seq(input int own, input int tgt, input int len, input int cid,
                         input int rsp, input int bad, input int err_at);
    arb_base = arbs; pstart = pops; nbytes = 0; bad_bytes = 0; seldb = -1;
    own_id = 3'(own); tgt_id = 3'(tgt); xfer_len = 8'(len);
    cmd_code = 8'h0B; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    chk(init_mode == 0 && int_good == 0 && irq == 0, "R2 start clears", {init_mode, irq}, 0);
    if (cid >= 0) begin
      for (int n = 0; n < 200 && !bsy_out; n++) @(negedge clk);
      oth_bsy = 1; oth_db = 8'(1 << cid);
      repeat (ARB + 2) @(negedge clk);
      oth_bsy = 0; oth_db = 0;
    end
    for (int n = 0; n < 300 && !(sel_out && !bsy_out); n++) @(negedge clk);
    seldb = int'(db_out);
    if (rsp != 0) begin
      tgt_bsy = 1;
      for (int n = 0; n < 50 && sel_out; n++) @(negedge clk);
      for (int k = 0; k < len; k++) begin
        if (k == bad) begin
          cd = 0; io = 1; req = 1;
          repeat (3) @(negedge clk);
          req = 0;
          break;
        end
        cd = 1; io = 0; msg = 0; req = 1;
        for (int n = 0; n < 50 && !ack_out; n++) @(negedge clk);
        if (ack_out) begin
          nbytes++;
          if (db_out != 8'((pstart + k) * 37 + 11)) bad_bytes++;
        end
        if (k == err_at) begin cmd_code = 8'h0B; cmd_valid = 1; end
        req = 0;
        @(negedge clk); cmd_valid = 0;
        for (int n = 0; n < 50 && ack_out; n++) @(negedge clk);
      end
    end else begin
      for (int n = 0; n < 200 && !int_sel_tmo; n++) @(negedge clk);
    end
    @(negedge clk);
    tgt_bsy = 0; cd = 0; io = 0; msg = 0;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1 reset state
    chk({bsy_out, sel_out, atn_out, ack_out, db_oe} == 0, "R1 bus idle", {bsy_out, sel_out, ack_out, db_oe}, 0);
    chk({int_good, int_sel_tmo, int_phase, int_cmd_err, irq, init_mode} == 0, "R1 flags", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 non-matching code while idle is ignored
    cmd_code = 8'h0C; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    repeat (FREE + ARB + 4) @(negedge clk);
    chk(!bsy_out && !sel_out && !irq && arbs == 0, "R2 other code ignored", arbs, 0);

    for (int i = 0; i < NV; i++) begin
      int exp_bytes;
      run_seq(V_OWN[i], V_TGT[i], V_LEN[i], V_CID[i], V_RSP[i], V_BAD[i], -1);
      exp_bytes = (V_OUT[i] == 0) ? V_LEN[i] : (V_OUT[i] == 2 ? V_BAD[i] : 0);
      chk(arbs - arb_base == V_ARB[i], "R5 arbitration rounds", arbs - arb_base, V_ARB[i]);
      chk(seldb == ((1 << V_OWN[i]) | (1 << V_TGT[i])), "R6 selection IDs", seldb,
          (1 << V_OWN[i]) | (1 << V_TGT[i]));
      chk(int_sel_tmo == (V_OUT[i] == 1) && !sel_out && !bsy_out, "R7 timeout/release", int_sel_tmo, V_OUT[i] == 1);
      chk(nbytes == exp_bytes && bad_bytes == 0 && pops - pstart == exp_bytes, "R8 bytes", nbytes, exp_bytes);
      chk(int_phase == (V_OUT[i] == 2), "R9 phase flag", int_phase, V_OUT[i] == 2);
      chk(int_good == (V_OUT[i] == 0) && init_mode == (V_OUT[i] == 0), "R10 good", int_good, V_OUT[i] == 0);
      chk(irq == 1, "R11 irq", irq, 1);
    end
    chk(atn_seen == 0, "R6 ATN never", atn_seen, 0);

    // R3 strobe in mid transfer
    run_seq(1, 6, 4, -1, 1, -1, 1);
    chk(int_cmd_err == 1 && int_good == 1 && nbytes == 4 && bad_bytes == 0, "R3 mid strobe", {int_cmd_err, int_good}, 3);

    // R3 strobe in the same cycle as completion
    run_seq(0, 2, 3, -1, 1, -1, 2);
    chk(int_cmd_err == 1 && int_good == 1 && init_mode == 1 && nbytes == 3, "R3 strobe at completion",
        {int_cmd_err, int_good}, 3);

    // R10 zero length
    run_seq(5, 3, 0, -1, 1, -1, -1);
    chk(int_good == 1 && pops == pstart && !sel_out, "R10 zero length", pops - pstart, 0);

    // R4 bus free window
    oth_bsy = 1;
    cmd_code = 8'h0B; xfer_len = 0; own_id = 3'd4; tgt_id = 3'd1; cmd_valid = 1;
    @(negedge clk); cmd_valid = 0;
    begin
      int seen, rise_at;
      seen = 0;
      for (int n = 0; n < 20; n++) begin @(negedge clk); if (bsy_out) seen++; end
      chk(seen == 0, "R4 no arb while busy", seen, 0);
      oth_bsy = 0;
      rise_at = -1;
      for (int n = 1; n <= 20 && rise_at < 0; n++) begin @(negedge clk); if (bsy_out) rise_at = n; end
      chk(rise_at == FREE, "R4 free window length", rise_at, FREE);
    end
    for (int n = 0; n < 50 && !(sel_out && !bsy_out); n++) @(negedge clk);
    tgt_bsy = 1;
    repeat (3) @(negedge clk);
    tgt_bsy = 0;
    chk(int_good == 1, "R10 after R4 run", int_good, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule